// File: doc/BRIEF.md
# Aperiodic Port Event Interrupt Controller

This block gathers event flags from a set of serial ports into one aperiodic interrupt line. Each port has four sources: monitor-channel receive, monitor-channel transmit, C/I-channel receive and C/I-channel transmit. An event pulse from a channel engine sets a sticky flag. The flag stays set until the processor reads that channel's own data register, which the block sees as a read strobe. All flags are shown in a status word, one bit per port for each source type.

Reading the status word drops the interrupt line. The line comes back on the following cycle if any flag that is still pending is enabled. Masking works at two levels: a whole port can be disabled, and each source within a port can be disabled. A masked event still records its flag, but it does not drive the line. Enabling a flag that is already pending raises the line.

Top module: `aper_irq_ctrl`

## Requirements
- R1: After reset the status word is all zero and the interrupt line is low.
- R2: An event pulse sets its flag, which is visible in the status word after the next clock edge. Status layout for NPORT=4: bits [3:0] monitor receive, [7:4] monitor transmit, [11:8] C/I receive, [15:12] C/I transmit. Bit p of each field is port p.
- R3: A set flag stays set across status reads and across read strobes of other sources or ports.
- R4: A read strobe for one source of one port clears only that flag, effective after the next clock edge.
- R5: When an event pulse and the clearing read strobe hit the same flag in the same cycle, the flag stays set.
- R6: An event that is enabled at both port and source level raises the interrupt line after the next clock edge.
- R7: A status read forces the line low after the next clock edge. If an enabled flag is still pending, the line returns high one cycle later.
- R8: An event whose source-enable bit is 0 sets its flag but leaves the line low. Source-enable bits use the same layout as the status word.
- R9: With a port-enable bit at 0, no source of that port drives the line, although its flags still set.
- R10: Enabling a pending flag, at source or port level, raises the line after the next clock edge.
- R11: The line goes low once every enabled flag has been cleared by its read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| port_en | input | NPORT | Per-port enable, 1 = port may interrupt |
| src_en | input | 4*NPORT | Per-source enable, same layout as status |
| evt_mrx | input | NPORT | Monitor receive event pulses |
| evt_mtx | input | NPORT | Monitor transmit event pulses |
| evt_crx | input | NPORT | C/I receive event pulses |
| evt_ctx | input | NPORT | C/I transmit event pulses |
| rd_mrx | input | NPORT | Monitor receive data register read strobes |
| rd_mtx | input | NPORT | Monitor transmit data register read strobes |
| rd_crx | input | NPORT | C/I receive data register read strobes |
| rd_ctx | input | NPORT | C/I transmit data register read strobes |
| stat_rd | input | 1 | Status word read strobe |
| status | output | 4*NPORT | Pending flags of all sources of all ports |
| irq | output | 1 | Aperiodic interrupt line |

## Verification
The tests drive event patterns that put one port in each source field, so a swapped field or port index shows up as a wrong bit. Selective read strobes on a fully set word show whether a read clears only its own flag, and an event that coincides with its own read shows which one wins. Source masks and port masks are each tested alone, with an unmask step afterwards, which separates the flag path from the line path. Status reads with flags still pending, and reads that drain flags one at a time, separate the one-cycle drop of the line from a real clear.

// File: rtl/aper_irq_ctrl.sv
module aper_irq_ctrl #(
  parameter int NPORT = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NPORT-1:0]   port_en,
  input  logic [4*NPORT-1:0] src_en,
  input  logic [NPORT-1:0]   evt_mrx,
  input  logic [NPORT-1:0]   evt_mtx,
  input  logic [NPORT-1:0]   evt_crx,
  input  logic [NPORT-1:0]   evt_ctx,
  input  logic [NPORT-1:0]   rd_mrx,
  input  logic [NPORT-1:0]   rd_mtx,
  input  logic [NPORT-1:0]   rd_crx,
  input  logic [NPORT-1:0]   rd_ctx,
  input  logic               stat_rd,
  output logic [4*NPORT-1:0] status,
  output logic               irq
);
  localparam int W = 4 * NPORT;

  logic [W-1:0] ev_all, rd_all, en_mask, flags_q, flags_d;
  logic         irq_q;

  assign ev_all  = {evt_ctx, evt_crx, evt_mtx, evt_mrx};
  assign rd_all  = {rd_ctx, rd_crx, rd_mtx, rd_mrx};
  assign en_mask = src_en & {4{port_en}};
  assign flags_d = (flags_q & ~rd_all) | ev_all;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flags_q <= '0;
      irq_q   <= 1'b0;
    end else begin
      flags_q <= flags_d;
      irq_q   <= !stat_rd && (|(flags_d & en_mask));
    end
  end

  assign status = flags_q;
  assign irq    = irq_q;

  // R2
  set_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|ev_all) |=> ((status & $past(ev_all)) == $past(ev_all)));

  // R4
  clr_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(rd_all & ~ev_all)) |=> ((status & $past(rd_all & ~ev_all)) == '0));

  // R3
  hold_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|status) |=> ((status & $past(status & ~rd_all)) == $past(status & ~rd_all)));

  // R7
  rd_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stat_rd |=> !irq);

  // R6
  irq_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!stat_rd && (|(ev_all & en_mask))) |=> irq);

  // R8
  irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (|(status & $past(en_mask))));
endmodule

// File: tb/sim_aper_irq_ctrl.sv
module sim_aper_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  port_en;
  logic [15:0] src_en, ev, rd, status;
  logic        stat_rd, irq;
  int          n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  aper_irq_ctrl #(.NPORT(4)) u0 (
    .clk(clk), .rst_n(rst_n), .port_en(port_en), .src_en(src_en),
    .evt_mrx(ev[3:0]), .evt_mtx(ev[7:4]), .evt_crx(ev[11:8]), .evt_ctx(ev[15:12]),
    .rd_mrx(rd[3:0]), .rd_mtx(rd[7:4]), .rd_crx(rd[11:8]), .rd_ctx(rd[15:12]),
    .stat_rd(stat_rd), .status(status), .irq(irq));

  task automatic chk_st(string tag, logic [15:0] exp);
    n_chk++;
    if (status !== exp) begin
      n_fail++;
      $display("FAIL %s status act=%h exp=%h", tag, status, exp);
    end
  endtask

  task automatic chk_irq(string tag, logic exp);
    n_chk++;
    if (irq !== exp) begin
      n_fail++;
      $display("FAIL %s irq act=%b exp=%b", tag, irq, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
    ev = '0; rd = '0; stat_rd = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; ev = '0; rd = '0; stat_rd = 1'b0;
    port_en = 4'hF; src_en = 16'hFFFF;
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_reset();
    do_reset();
    chk_st("R1", 16'h0000);
    chk_irq("R1", 1'b0);
  endtask

  task automatic t_set();
    do_reset();
    ev = 16'h8421; cyc();
    chk_st("R2", 16'h8421);
    chk_irq("R6", 1'b1);
  endtask

  task automatic t_hold_clear();
    do_reset();
    ev = 16'hFFFF; cyc();
    stat_rd = 1'b1; cyc();
    chk_st("R3", 16'hFFFF);
    chk_irq("R7 drop", 1'b0);
    cyc();
    chk_irq("R7 return", 1'b1);
    rd = 16'h00F0; cyc();
    chk_st("R4", 16'hFF0F);
    rd = 16'h1000; cyc();
    chk_st("R4 single", 16'hEF0F);
  endtask

  task automatic t_same();
    do_reset();
    ev = 16'h0008; cyc();
    ev = 16'h0008; rd = 16'h0008; cyc();
    chk_st("R5", 16'h0008);
  endtask

  task automatic t_srcmask();
    do_reset();
    src_en = ~16'h0010;
    ev = 16'h0010; cyc();
    chk_st("R8", 16'h0010);
    chk_irq("R8", 1'b0);
    src_en = 16'hFFFF; cyc();
    chk_irq("R10 src", 1'b1);
  endtask

  task automatic t_portmask();
    do_reset();
    port_en = 4'b1101;
    ev = 16'h2222; cyc();
    chk_st("R9", 16'h2222);
    chk_irq("R9", 1'b0);
    port_en = 4'hF; cyc();
    chk_irq("R10 port", 1'b1);
  endtask

  task automatic t_drain();
    do_reset();
    ev = 16'h0003; cyc();
    rd = 16'h0001; cyc();
    chk_irq("R11 partial", 1'b1);
    rd = 16'h0002; cyc();
    chk_st("R11", 16'h0000);
    chk_irq("R11", 1'b0);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    n_fail++; n_chk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0; ev = '0; rd = '0; stat_rd = 1'b0;
    port_en = 4'hF; src_en = 16'hFFFF;
    t_reset();
    t_set();
    t_hold_clear();
    t_same();
    t_srcmask();
    t_portmask();
    t_drain();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule